// File: doc/BRIEF.md
# Dot-Matrix Display Instruction Decoder

This block sits behind the serial front end of a dot-matrix LCD controller. It receives each complete 16-bit instruction in parallel, with a one-cycle valid strobe, and decodes the opcode in the top nibble. It then updates the controller state that the rest of the chip reads: the address counter, the scroll offsets of the main and auxiliary data planes, the output-blanking flag and the sleep flag. It also drives the oscillator enable and a force-off output that parks every segment and common driver at the off level.

Instruction word bit `k` of `cmd_word` carries serial data bit D(48+k). The opcode is `cmd_word[15:12]`, with D63 as its MSB. With the default parameters, 4'hC is the display-shift instruction, 4'h2 loads the address counter, and 4'h1 controls the display on/off state. The opcodes 4'h5 (contrast), 4'h9 (key-scan output) and 4'hD (general-purpose port) belong to neighbouring registers. For those, this block only issues the execute strobe.

While asleep, the block executes only the four whitelisted opcodes and drops every other word. The oscillator stays stopped in sleep, except while a key scan is running.

Top module: `lcd_cmd_decoder`

## Requirements
- R1: After reset, char_addr=0, aux_addr=0, main_ofs=0, aux_ofs=0, blank=1, sleep=0, force_off=1, osc_en=1 and exec_stb=0.
- R2: An executed opcode 4'h2 loads char_addr from cmd_word[5:0] (D48 is the LSB) and aux_addr from cmd_word[11:8] (D56 is the LSB), on the clock edge that samples cmd_valid.
- R3: An executed opcode 4'hC moves main_ofs when cmd_word[8] (M) is 1 and moves aux_ofs when cmd_word[9] (A) is 1. A plane whose select bit is 0 keeps its offset.
- R4: With cmd_word[10]=0 a shift adds one to the offset, wrapping from DISP_W-1 to 0. With cmd_word[10]=1 it subtracts one, wrapping from 0 to DISP_W-1.
- R5: cmd_word[7:6] have no effect on a set-address instruction, and cmd_word[11] has no effect on a shift instruction.
- R6: An executed opcode 4'h1 loads blank from cmd_word[8] and sleep from cmd_word[9]. This happens in both normal and sleep mode.
- R7: force_off is 1 exactly when blank or sleep is 1.
- R8: osc_en is 0 exactly when sleep is 1 and key_scan_active is 0.
- R9: While sleep=1, opcodes other than 4'h1, 4'h5, 4'h9 and 4'hD change no register and give no exec_stb.
- R10: exec_stb is 1 for one cycle after every executed instruction: any opcode in normal mode, and whitelisted opcodes in sleep. It is 0 otherwise.
- R11: A cycle with cmd_valid=0 leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | One-cycle strobe marking a complete instruction |
| cmd_word | input | 16 | Instruction bits; bit k carries D(48+k) |
| key_scan_active | input | 1 | High while a key scan is in progress |
| char_addr | output | 6 | Character RAM address of the address counter |
| aux_addr | output | 4 | Auxiliary RAM address of the address counter |
| main_ofs | output | $clog2(DISP_W) | Scroll offset of the main data plane |
| aux_ofs | output | $clog2(DISP_W) | Scroll offset of the auxiliary data plane |
| blank | output | 1 | Output-blanking flag |
| sleep | output | 1 | Sleep-mode flag |
| osc_en | output | 1 | Oscillator enable |
| force_off | output | 1 | Forces all driver pins to the off level |
| exec_stb | output | 1 | Pulses the cycle after an instruction is executed |

## Verification
Each register result of an instruction (address, offsets, flags, execute strobe) is due one clock after the edge that samples cmd_valid. force_off and osc_en follow the flags and key_scan_active in the same cycle, with no extra register. The bench drives its inputs and compares every output on the falling edge. Its reference model updates on the rising edge from the same sampled inputs, so each comparison falls half a cycle after the edge that made the result. The whitelist check sweeps all sixteen opcodes in sleep and compares the registers and the strobe one cycle after each word.

// File: rtl/lcd_cmd_pkg.sv
package lcd_cmd_pkg;
  localparam int WORD_W  = 16;
  localparam int OPC_W   = 4;
  localparam int CADDR_W = 6;
  localparam int AADDR_W = 4;

  typedef enum logic {SH_LEFT = 1'b0, SH_RIGHT = 1'b1} shift_dir_e;

  // one step of a modulo-modn counter, up for left, down for right
  function automatic int wrap_step(int cur, shift_dir_e dir, int modn);
    if (dir == SH_RIGHT) return (cur == 0) ? modn - 1 : cur - 1;
    return (cur == modn - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/lcd_cmd_gate.sv
module lcd_cmd_gate #(
  parameter logic [3:0] OP_SHIFT    = 4'hC,
  parameter logic [3:0] OP_SETAC    = 4'h2,
  parameter logic [3:0] OP_DISP     = 4'h1,
  parameter logic [3:0] OP_CONTRAST = 4'h5,
  parameter logic [3:0] OP_KEYOUT   = 4'h9,
  parameter logic [3:0] OP_PORT     = 4'hD
) (
  input  logic       valid,
  input  logic [3:0] opcode,
  input  logic       asleep,
  output logic       exec,
  output logic       hit_shift,
  output logic       hit_setac,
  output logic       hit_disp
);
  logic allowed_in_sleep;

  always_comb begin
    allowed_in_sleep = (opcode == OP_DISP) || (opcode == OP_CONTRAST) ||
                       (opcode == OP_KEYOUT) || (opcode == OP_PORT);
    exec      = valid && (!asleep || allowed_in_sleep);
    hit_shift = exec && (opcode == OP_SHIFT);
    hit_setac = exec && (opcode == OP_SETAC);
    hit_disp  = exec && (opcode == OP_DISP);
  end
endmodule

// File: rtl/lcd_shift_ofs.sv
module lcd_shift_ofs #(
  parameter int DISP_W = 60,
  localparam int OFS_W = $clog2(DISP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             dir_right,
  output logic [OFS_W-1:0] ofs
);
  import lcd_cmd_pkg::*;

  shift_dir_e dir;
  assign dir = dir_right ? SH_RIGHT : SH_LEFT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ofs <= '0;
    else if (step_en) ofs <= OFS_W'(wrap_step(int'(ofs), dir, DISP_W));
  end
endmodule

// File: rtl/lcd_cmd_decoder.sv
module lcd_cmd_decoder #(
  parameter int DISP_W = 60,
  parameter logic [3:0] OP_SHIFT    = 4'hC,
  parameter logic [3:0] OP_SETAC    = 4'h2,
  parameter logic [3:0] OP_DISP     = 4'h1,
  parameter logic [3:0] OP_CONTRAST = 4'h5,
  parameter logic [3:0] OP_KEYOUT   = 4'h9,
  parameter logic [3:0] OP_PORT     = 4'hD,
  localparam int OFS_W = $clog2(DISP_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [15:0]      cmd_word,
  input  logic             key_scan_active,
  output logic [5:0]       char_addr,
  output logic [3:0]       aux_addr,
  output logic [OFS_W-1:0] main_ofs,
  output logic [OFS_W-1:0] aux_ofs,
  output logic             blank,
  output logic             sleep,
  output logic             osc_en,
  output logic             force_off,
  output logic             exec_stb
);
  import lcd_cmd_pkg::*;

  localparam int OPC_LSB = WORD_W - OPC_W;

  logic [OPC_W-1:0] opcode;
  logic exec_now, hit_shift, hit_setac, hit_disp;
  logic [1:0] plane_sel;
  logic [OFS_W-1:0] plane_ofs [2];

  assign opcode    = cmd_word[WORD_W-1:OPC_LSB];
  assign plane_sel = cmd_word[9:8];   // bit 8 main plane, bit 9 auxiliary plane

  lcd_cmd_gate #(
    .OP_SHIFT(OP_SHIFT), .OP_SETAC(OP_SETAC), .OP_DISP(OP_DISP),
    .OP_CONTRAST(OP_CONTRAST), .OP_KEYOUT(OP_KEYOUT), .OP_PORT(OP_PORT)
  ) gate_i (
    .valid(cmd_valid), .opcode(opcode), .asleep(sleep),
    .exec(exec_now), .hit_shift(hit_shift), .hit_setac(hit_setac), .hit_disp(hit_disp)
  );

  for (genvar p = 0; p < 2; p++) begin : g_plane
    lcd_shift_ofs #(.DISP_W(DISP_W)) ofs_i (
      .clk(clk), .rst_n(rst_n),
      .step_en(hit_shift && plane_sel[p]),
      .dir_right(cmd_word[10]),
      .ofs(plane_ofs[p])
    );
  end

  assign main_ofs = plane_ofs[0];
  assign aux_ofs  = plane_ofs[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      char_addr <= '0;
      aux_addr  <= '0;
      blank     <= 1'b1;
      sleep     <= 1'b0;
      exec_stb  <= 1'b0;
    end else begin
      exec_stb <= exec_now;
      if (hit_setac) begin
        char_addr <= cmd_word[CADDR_W-1:0];
        aux_addr  <= cmd_word[8 +: AADDR_W];
      end
      if (hit_disp) begin
        blank <= cmd_word[8];
        sleep <= cmd_word[9];
      end
    end
  end

  assign force_off = blank | sleep;
  assign osc_en    = !sleep | key_scan_active;
endmodule

// File: rtl/lcd_cmd_decoder_chk.sv
module lcd_cmd_decoder_chk #(
  parameter int OFS_W = 6,
  parameter logic [3:0] OP_DISP     = 4'h1,
  parameter logic [3:0] OP_CONTRAST = 4'h5,
  parameter logic [3:0] OP_KEYOUT   = 4'h9,
  parameter logic [3:0] OP_PORT     = 4'hD
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic [15:0]      cmd_word,
  input logic             key_scan_active,
  input logic [5:0]       char_addr,
  input logic [3:0]       aux_addr,
  input logic [OFS_W-1:0] main_ofs,
  input logic [OFS_W-1:0] aux_ofs,
  input logic             blank,
  input logic             sleep,
  input logic             osc_en,
  input logic             force_off,
  input logic             exec_stb
);
  logic wl_now, blocked_now;
  assign wl_now = (cmd_word[15:12] == OP_DISP) || (cmd_word[15:12] == OP_CONTRAST) ||
                  (cmd_word[15:12] == OP_KEYOUT) || (cmd_word[15:12] == OP_PORT);
  assign blocked_now = cmd_valid && sleep && !wl_now;

  // R7
  sleep_forces_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep || blank) |-> force_off);

  // R8
  osc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && !key_scan_active) |-> !osc_en);

  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blocked_now |=> ($stable(char_addr) && $stable(aux_addr) && $stable(main_ofs) &&
                     $stable(aux_ofs) && $stable(blank) && $stable(sleep) && !exec_stb));

  // R10
  exec_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> !exec_stb);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ($stable(char_addr) && $stable(aux_addr) && $stable(main_ofs) &&
                    $stable(aux_ofs) && $stable(blank) && $stable(sleep)));
endmodule

bind lcd_cmd_decoder lcd_cmd_decoder_chk #(
  .OFS_W(OFS_W), .OP_DISP(OP_DISP), .OP_CONTRAST(OP_CONTRAST),
  .OP_KEYOUT(OP_KEYOUT), .OP_PORT(OP_PORT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
  .key_scan_active(key_scan_active), .char_addr(char_addr), .aux_addr(aux_addr),
  .main_ofs(main_ofs), .aux_ofs(aux_ofs), .blank(blank), .sleep(sleep),
  .osc_en(osc_en), .force_off(force_off), .exec_stb(exec_stb)
);

// File: tb/lcd_cmd_decoder_test.sv
module lcd_cmd_decoder_test;
  localparam int W = 60;
  localparam int OW = $clog2(W);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic key_scan_active = 1'b0;
  logic [5:0] char_addr;
  logic [3:0] aux_addr;
  logic [OW-1:0] main_ofs, aux_ofs;
  logic blank, sleep, osc_en, force_off, exec_stb;

  int checks = 0;
  int errors = 0;

  // reference model state
  int m_cadr, m_aadr, m_sc, m_sp, m_ex;
  int m_ofs [2];

  lcd_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .key_scan_active(key_scan_active), .char_addr(char_addr), .aux_addr(aux_addr),
    .main_ofs(main_ofs), .aux_ofs(aux_ofs), .blank(blank), .sleep(sleep),
    .osc_en(osc_en), .force_off(force_off), .exec_stb(exec_stb)
  );

  always #5 clk = ~clk;

  function automatic bit sleep_ok(int op);
    return op == 1 || op == 5 || op == 9 || op == 13;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cadr <= 0; m_aadr <= 0; m_sc <= 1; m_sp <= 0; m_ex <= 0;
      m_ofs[0] <= 0; m_ofs[1] <= 0;
    end else begin
      int op;
      op = int'(cmd_word) / 4096;
      m_ex <= 0;
      if (cmd_valid && (m_sp == 0 || sleep_ok(op))) begin
        m_ex <= 1;
        if (op == 2) begin
          m_cadr <= int'(cmd_word) % 64;
          m_aadr <= (int'(cmd_word) / 256) % 16;
        end else if (op == 1) begin
          m_sc <= int'(cmd_word[8]);
          m_sp <= int'(cmd_word[9]);
        end else if (op == 12) begin
          for (int p = 0; p < 2; p++)
            if (cmd_word[8+p])
              m_ofs[p] <= cmd_word[10] ? (m_ofs[p] + W - 1) % W : (m_ofs[p] + 1) % W;
        end
      end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model, half a cycle after each edge
  always @(negedge clk) if (rst_n) begin
    check("R2 char_addr", int'(char_addr), m_cadr);
    check("R2 aux_addr", int'(aux_addr), m_aadr);
    check("R3 main_ofs", int'(main_ofs), m_ofs[0]);
    check("R3 aux_ofs", int'(aux_ofs), m_ofs[1]);
    check("R6 blank", int'(blank), m_sc);
    check("R6 sleep", int'(sleep), m_sp);
    check("R7 force_off", int'(force_off), (m_sc != 0 || m_sp != 0) ? 1 : 0);
    check("R8 osc_en", int'(osc_en), (m_sp == 0 || key_scan_active) ? 1 : 0);
    check("R10 exec_stb", int'(exec_stb), m_ex);
  end

  task automatic send(logic [15:0] w);
    @(negedge clk);
    cmd_word = w; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_word = 16'h0000;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 char_addr", int'(char_addr), 0);
    check("R1 aux_addr", int'(aux_addr), 0);
    check("R1 ofs", int'(main_ofs) + int'(aux_ofs), 0);
    check("R1 blank", int'(blank), 1);
    check("R1 sleep", int'(sleep), 0);
    check("R1 force_off", int'(force_off), 1);
    check("R1 osc_en", int'(osc_en), 1);
    check("R1 exec_stb", int'(exec_stb), 0);
    rst_n = 1'b1;

    // R2 / R5: set address with junk in bits 7:6
    send(16'h2AE5);
    check("R2 R5 char_addr", int'(char_addr), 37);
    check("R2 aux_addr", int'(aux_addr), 10);
    send(16'h2F3F);
    check("R2 char_addr max", int'(char_addr), 63);
    check("R2 aux_addr max", int'(aux_addr), 15);

    // R6 / R7: display on
    send(16'h1000);
    check("R7 force_off low", int'(force_off), 0);

    // R3 / R4: left shifts of the main plane across the wrap, bit 11 set (R5)
    for (int i = 0; i < W + 2; i++) send(16'hC900);
    check("R4 main wrap left", int'(main_ofs), 2);
    check("R3 aux untouched", int'(aux_ofs), 0);
    // right shift of aux plane from 0 wraps to W-1
    send(16'hC600);
    check("R4 aux wrap right", int'(aux_ofs), W - 1);
    check("R3 main untouched", int'(main_ofs), 2);
    // both planes right, then none selected
    send(16'hC700);
    check("R3 both main", int'(main_ofs), 1);
    check("R3 both aux", int'(aux_ofs), W - 2);
    send(16'hCC00);
    check("R3 no plane", int'(main_ofs) * 100 + int'(aux_ofs), 100 + W - 2);

    // R11 idle cycles
    repeat (5) @(negedge clk);
    check("R11 idle char_addr", int'(char_addr), 63);

    // R6 sleep, R8 oscillator
    send(16'h1200);
    check("R6 sleep set", int'(sleep), 1);
    check("R8 osc off", int'(osc_en), 0);
    key_scan_active = 1'b1;
    @(negedge clk);
    check("R8 osc on during scan", int'(osc_en), 1);
    key_scan_active = 1'b0;
    @(negedge clk);

    // R9 whitelist sweep while asleep (skip op 1 until the end)
    for (int op = 0; op < 16; op++) begin
      if (op != 1) begin
        send(16'(op * 4096 + 16'h0F3F));
        check("R9 exec", int'(exec_stb), sleep_ok(op) ? 1 : 0);
        check("R9 char_addr", int'(char_addr), 63);
        check("R9 main_ofs", int'(main_ofs), 1);
        check("R9 aux_ofs", int'(aux_ofs), W - 2);
        check("R9 sleep", int'(sleep), 1);
      end
    end
    // wake with blank set
    send(16'h1100);
    check("R6 wake", int'(sleep), 0);
    check("R7 blanked", int'(force_off), 1);
    send(16'h2001);
    check("R2 after wake", int'(char_addr), 1);
    repeat (3) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule